// File: doc/BRIEF.md
# Per-Port Burst Address Generator

This block produces the address a synchronous memory port presents to its storage array in every clock cycle. The port's user either supplies an address directly through an active-low strobe, or lets an internal counter step through consecutive locations for burst transfers. An active-low clear input returns the sequence to location zero. All controls are sampled on the rising clock edge.

The presented address is combinational from the controls and the stored counter. This means a strobed address, a cleared address, or the next step of a burst is usable for an array access in the same cycle, with no dead cycle. The stored counter takes whatever address was presented at each rising edge. The controls follow a fixed priority: clear first, then the strobe, then count enable.

The block has no chip-select input, so it keeps counting whether or not the port is selected. The address width is a parameter (12 or 13 bits for the intended arrays), and the counter wraps across the whole address space.

Operations, decoded each cycle into an enumerated operation code:
- CLEAR: the clear input is low. The presented address is 0.
- LOAD: clear is high and the strobe is low. The presented address is the external address.
- STEP: clear and strobe are high and count enable is low. The presented address is the stored value plus one, wrapping to 0.
- HOLD: all three controls are high. The presented address is the stored value.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-low system reset `rst_n` is low at a rising edge, the stored counter becomes 0. The first HOLD cycle after reset presents address 0.
- R2: When `cnt_clr_n` is low, `cur_addr` is 0 in that same cycle, whatever the values of `strobe_n`, `cnt_en_n` and `ext_addr`.
- R3: When `cnt_clr_n` is high and `strobe_n` is low, `cur_addr` equals `ext_addr` in that same cycle. That value is stored at the rising edge.
- R4: When `cnt_clr_n` and `strobe_n` are high and `cnt_en_n` is low, `cur_addr` equals the stored value plus one. The result is stored at the edge, so the address advances once per clock.
- R5: When all three controls are high, `cur_addr` equals the stored value and does not change. `ext_addr` has no effect.
- R6: `cnt_en_n` has no effect while `cnt_clr_n` or `strobe_n` is low.
- R7: A STEP from the highest address, 2^ADDR_W-1, presents address 0.
- R8: A clear cycle is followed directly by usable addresses. A STEP in the very next cycle presents address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low system reset of the stored counter |
| ext_addr | input | ADDR_W | Externally supplied address |
| strobe_n | input | 1 | Active-low address strobe: present and store `ext_addr` |
| cnt_en_n | input | 1 | Active-low count enable: step the address by one |
| cnt_clr_n | input | 1 | Active-low clear: present and store address 0 |
| cur_addr | output | ADDR_W | Address driven to the array in this cycle |

## Verification
The bench builds the block with ADDR_W = 4. At that width the whole address space has 16 locations. This lets every location be loaded, and bursts of twenty steps cross the wrap from 15 to 0 from every starting point. At that width the bench also drives every one of the eight clear/strobe/enable combinations against every external address value. This covers every priority case and every ignored-input case. The expected address is computed arithmetically as a modulo-16 sum from the bench's own running copy of the stored value.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Operation selected for the current cycle, in priority order
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } addr_op_e;

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
    import burst_addr_pkg::*;
(
    input  logic     clr_n,
    input  logic     stb_n,
    input  logic     en_n,
    output addr_op_e op
);

    // Clear outranks strobe, strobe outranks count enable
    always_comb begin
        unique casez ({clr_n, stb_n, en_n})
            3'b0??:  op = OP_CLEAR;
            3'b10?:  op = OP_LOAD;
            3'b110:  op = OP_STEP;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/burst_addr_select.sv
module burst_addr_select
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  addr_op_e          op,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] stored,
    output logic [ADDR_W-1:0] addr_now
);

    localparam logic [ADDR_W-1:0] ADDR_TOP  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] ADDR_ZERO = '0;

    logic [ADDR_W-1:0] stepped;

    // Explicit wrap from the top of the array back to zero
    always_comb begin
        if (stored == ADDR_TOP) begin
            stepped = ADDR_ZERO;
        end else begin
            stepped = stored + 1'b1;
        end
    end

    always_comb begin
        unique case (op)
            OP_CLEAR: addr_now = ADDR_ZERO;
            OP_LOAD:  addr_now = ext_addr;
            OP_STEP:  addr_now = stepped;
            OP_HOLD:  addr_now = stored;
            default:  addr_now = stored;
        endcase
    end

endmodule

// File: rtl/burst_addr_store.sv
module burst_addr_store #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_now,
    output logic [ADDR_W-1:0] stored
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else begin
            stored <= addr_now;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              cnt_en_n,
    input  logic              cnt_clr_n,
    output logic [ADDR_W-1:0] cur_addr
);

    addr_op_e          op;
    logic [ADDR_W-1:0] stored;
    logic [ADDR_W-1:0] addr_now;

    burst_op_decode u_decode (
        .clr_n (cnt_clr_n),
        .stb_n (strobe_n),
        .en_n  (cnt_en_n),
        .op    (op)
    );

    burst_addr_select #(.ADDR_W(ADDR_W)) u_select (
        .op       (op),
        .ext_addr (ext_addr),
        .stored   (stored),
        .addr_now (addr_now)
    );

    burst_addr_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_now (addr_now),
        .stored   (stored)
    );

    assign cur_addr = addr_now;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strobe_n,
    input logic              cnt_en_n,
    input logic              cnt_clr_n,
    input logic [ADDR_W-1:0] cur_addr
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic was_run;
    logic was_rst;

    always_ff @(posedge clk) begin
        was_run <= rst_n;
        was_rst <= !rst_n;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst === 1'b1 && cnt_clr_n && strobe_n && cnt_en_n) |-> cur_addr == '0) // R1
        else $error("AST_RESET_ZERO");

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_n |-> cur_addr == '0) // R2
        else $error("AST_CLEAR_ZERO");

    AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_n && !strobe_n) |-> cur_addr == ext_addr) // R3
        else $error("AST_LOAD_PASS");

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run === 1'b1 && cnt_clr_n && strobe_n && !cnt_en_n)
            |-> cur_addr == $past(cur_addr) + ONE) // R4
        else $error("AST_STEP_ONE");

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run === 1'b1 && cnt_clr_n && strobe_n && cnt_en_n)
            |-> $stable(cur_addr)) // R5
        else $error("AST_HOLD_STABLE");

    AST_EN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_n && (!cnt_clr_n || !strobe_n))
            |-> cur_addr == (cnt_clr_n ? ext_addr : '0)) // R6
        else $error("AST_EN_MASKED");

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run === 1'b1 && cnt_clr_n && strobe_n && !cnt_en_n
            && $past(cur_addr) == {ADDR_W{1'b1}}) |-> cur_addr == '0) // R7
        else $error("AST_WRAP_ZERO");

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .cnt_en_n  (cnt_en_n),
    .cnt_clr_n (cnt_clr_n),
    .cur_addr  (cur_addr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int W    = 4;
    localparam int SPAN = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ext_addr = '0;
    logic         strobe_n = 1'b1;
    logic         cnt_en_n = 1'b1;
    logic         cnt_clr_n = 1'b1;
    logic [W-1:0] cur_addr;

    int n_chk  = 0;
    int n_fail = 0;
    int model  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_addr  (ext_addr),
        .strobe_n  (strobe_n),
        .cnt_en_n  (cnt_en_n),
        .cnt_clr_n (cnt_clr_n),
        .cur_addr  (cur_addr)
    );

    task automatic check(input string req, input int exp);
        n_chk++;
        if (cur_addr !== W'(exp)) begin
            n_fail++;
            $display("FAIL %s: cur_addr=%0d expected=%0d", req, cur_addr, exp);
        end
    endtask

    // One cycle: drive after the falling edge, sample before the rising edge
    task automatic cyc(input bit clr, input bit stb, input bit en, input int ext);
        int    exp;
        string req;
        @(negedge clk);
        cnt_clr_n = clr;
        strobe_n  = stb;
        cnt_en_n  = en;
        ext_addr  = W'(ext);
        #3;
        if (!clr) begin
            exp = 0;
            req = en ? "R2" : "R6";
        end else if (!stb) begin
            exp = ext % SPAN;
            req = en ? "R3" : "R6";
        end else if (!en) begin
            exp = (model + 1) % SPAN;
            req = (model == SPAN - 1) ? "R7" : "R4";
        end else begin
            exp = model;
            req = "R5";
        end
        check(req, exp);
        model = exp;
    endtask

    task automatic sys_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cnt_clr_n = 1'b1;
        strobe_n = 1'b1;
        cnt_en_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then a HOLD cycle presents 0
        sys_reset();
        #3;
        check("R1", 0);
        cyc(1, 1, 1, 9);

        // R3/R4/R7/R5: load each location, burst across the wrap, then hold
        for (int a = 0; a < SPAN; a++) begin
            cyc(1, 0, 1, a);
            for (int s = 0; s < 20; s++) cyc(1, 1, 0, (a + 5) % SPAN);
            for (int h = 0; h < 3; h++) cyc(1, 1, 1, (a * 7 + h) % SPAN);
        end

        // R2/R6: all control combinations against every external value
        for (int c = 0; c < 8; c++) begin
            for (int e = 0; e < SPAN; e++) begin
                cyc(c[2], c[1], c[0], e);
                cyc(1, 1, 1, (e + 3) % SPAN);
            end
        end

        // R8: clear, then the next step presents address 1
        cyc(1, 0, 1, 11);
        cyc(0, 1, 1, 6);
        cyc(1, 1, 0, 6);
        check("R8", 1);

        // R1: reset in the middle of a burst
        cyc(1, 0, 1, 13);
        cyc(1, 1, 0, 0);
        sys_reset();
        #3;
        check("R1", 0);
        cyc(1, 1, 0, 2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule